// File: doc/BRIEF.md
# Audio Serial Clock Enable Generator

This block derives the three timing strobes of a serial audio link from a source tick that runs in the system clock domain. One of two source ticks is chosen: a peripheral-clock tick or an external audio-clock tick. An optional prescaler thins that tick into the root audio strobe. Two ratio codes then set how many root periods and how many bit periods make up one audio frame. From those codes the block derives the bit-clock divisor and the frame-clock divisor.

Every generated clock is a one-cycle enable pulse in the system clock domain. Each pulse marks one edge of the clock it stands for, so downstream shifters simply gate on it. The block also keeps level copies of the bit clock and of the channel index (left = 0, right = 1). One configuration word is written with a single-cycle strobe. Each write restarts every divider, so the new ratios take effect from the start of a fresh frame. A ratio pair that cannot divide evenly is flagged, and nothing is generated while it is selected.

Top module: `aclk_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `rclk_en`, `bclk_en` and `lrclk_en` are 0, `lr_index` and `bclk_lvl` are 0, and `cfg_err` is 0. The reset configuration word is all zeros.
- R2: Configuration bit 4 selects the source tick: 0 takes `pclk_tick`, 1 takes `aud_tick`. The source that is not selected has no effect on any output.
- R3: Bit 7 enables the prescaler and bits 8 upward hold its value N. When bit 7 is set, `rclk_en` pulses once every N+1 source ticks. When bit 7 is clear, `rclk_en` pulses on every source tick, whatever the value in N.
- R4: Bits 1:0 set the root-to-frame ratio: 0=256, 1=384, 2=512, 3=768. Bits 3:2 set the bit-to-frame ratio: 0=16, 1=24, 2=32, 3=48. `bclk_en` pulses once every (root ratio / bit ratio)/2 `rclk_en` pulses, and `bclk_lvl` toggles one cycle after each `bclk_en` pulse.
- R5: `lrclk_en` pulses once every (bit ratio) `bclk_en` pulses, which is half a frame. `lr_index` toggles one cycle after each `lrclk_en` pulse and at no other time, except for a configuration write.
- R6: A root ratio of 256 or 512 combined with a bit ratio of 24 or 48 sets `cfg_err` to 1. While `cfg_err` is 1, none of the three enable outputs pulses.
- R7: A configuration write clears every divider. In the following cycle `lr_index` and `bclk_lvl` are 0, and the new settings apply from that cycle.
- R8: `bclk_en` and `lrclk_en` are never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pclk_tick | input | 1 | Peripheral-clock source tick |
| aud_tick | input | 1 | External audio-clock source tick |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8+PRE_W | Configuration word |
| rclk_en | output | 1 | Root audio clock enable pulse |
| bclk_en | output | 1 | Bit clock edge pulse |
| bclk_lvl | output | 1 | Bit clock level |
| lrclk_en | output | 1 | Frame clock edge pulse |
| lr_index | output | 1 | Current channel half (0 left, 1 right) |
| cfg_err | output | 1 | Ratio pair cannot divide evenly |

## Verification
The bench measures the spacing between successive pulses of each strobe under four valid settings. These settings differ in source, prescaler value and enable, and both ratio codes. They separate a wrong source pick, an off-by-one in the prescaler, and a mixed-up ratio table or halving step.

A slow audio tick is paired with an always-high peripheral tick. This exposes any leak from the source that is not selected. A set prescaler value with the enable bit clear shows whether the enable is honoured.

Two invalid ratio pairs must raise the error flag and stop all pulses. After each write the channel index and bit level are checked, to confirm that the write restarts the frame.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    localparam int PRE_W_DEF = 8;

    typedef enum logic [1:0] {
        RFS_256 = 2'd0,
        RFS_384 = 2'd1,
        RFS_512 = 2'd2,
        RFS_768 = 2'd3
    } rfs_code_e;

    typedef enum logic [1:0] {
        BFS_16 = 2'd0,
        BFS_24 = 2'd1,
        BFS_32 = 2'd2,
        BFS_48 = 2'd3
    } bfs_code_e;

    typedef struct packed {
        logic      pre_en;
        logic      src_sel;
        bfs_code_e bfs;
        rfs_code_e rfs;
    } cfg_flags_t;

    function automatic int rfs_ratio(rfs_code_e c);
        case (c)
            RFS_256: return 256;
            RFS_384: return 384;
            RFS_512: return 512;
            default: return 768;
        endcase
    endfunction

    function automatic int bfs_ratio(bfs_code_e c);
        case (c)
            BFS_16:  return 16;
            BFS_24:  return 24;
            BFS_32:  return 32;
            default: return 48;
        endcase
    endfunction

    function automatic logic pair_ok(rfs_code_e r, bfs_code_e b);
        int q;
        if ((rfs_ratio(r) % bfs_ratio(b)) != 0) return 1'b0;
        q = rfs_ratio(r) / bfs_ratio(b);
        return (q % 2) == 0;
    endfunction

endpackage

// File: rtl/aclk_tick_div.sv
module aclk_tick_div #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick_in,
    input  logic [CNT_W-1:0] limit,
    output logic             tick_out
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt      <= '0;
            tick_out <= 1'b0;
        end else if (tick_in) begin
            if (cnt >= limit) begin
                cnt      <= '0;
                tick_out <= 1'b1;
            end else begin
                cnt      <= cnt + 1'b1;
                tick_out <= 1'b0;
            end
        end else begin
            tick_out <= 1'b0;
        end
    end

    // R4: an output pulse is always caused by an input tick one cycle earlier
    assert_pulse_follows_tick_R4: assert property (@(posedge clk) disable iff (rst)
        tick_out |-> ($past(tick_in) && !$past(clr)));

endmodule

// File: rtl/aclk_cfg_reg.sv
module aclk_cfg_reg
    import aclk_pkg::*;
#(
    parameter int PRE_W = PRE_W_DEF,
    parameter int CNT_W = 8,
    localparam int CFG_W = 8 + PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             src_sel,
    output logic             err,
    output logic [CNT_W-1:0] pre_lim,
    output logic [CNT_W-1:0] half_lim,
    output logic [CNT_W-1:0] lr_lim
);
    cfg_flags_t       flags;
    logic [PRE_W-1:0] pre_val;
    int               half_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            pre_val <= '0;
        end else if (cfg_wr) begin
            flags.rfs     <= rfs_code_e'(cfg_wdata[1:0]);
            flags.bfs     <= bfs_code_e'(cfg_wdata[3:2]);
            flags.src_sel <= cfg_wdata[4];
            flags.pre_en  <= cfg_wdata[7];
            pre_val       <= cfg_wdata[8 +: PRE_W];
        end
    end

    always_comb begin
        half_cnt = rfs_ratio(flags.rfs) / bfs_ratio(flags.bfs) / 2;
        src_sel  = flags.src_sel;
        err      = !pair_ok(flags.rfs, flags.bfs);
        pre_lim  = flags.pre_en ? CNT_W'(pre_val) : '0;
        half_lim = CNT_W'(half_cnt - 1);
        lr_lim   = CNT_W'(bfs_ratio(flags.bfs) - 1);
    end

endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
    import aclk_pkg::*;
#(
    parameter int PRE_W = PRE_W_DEF,
    localparam int CFG_W = 8 + PRE_W,
    localparam int CNT_W = (PRE_W > 6) ? PRE_W : 6,
    localparam int NSTG  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pclk_tick,
    input  logic             aud_tick,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             rclk_en,
    output logic             bclk_en,
    output logic             bclk_lvl,
    output logic             lrclk_en,
    output logic             lr_index,
    output logic             cfg_err
);
    logic                       src_sel;
    logic                       clr;
    logic [NSTG:0]              chain;
    logic [NSTG-1:0][CNT_W-1:0] lim;

    aclk_cfg_reg #(.PRE_W(PRE_W), .CNT_W(CNT_W)) cfg_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_wdata(cfg_wdata),
        .src_sel  (src_sel),
        .err      (cfg_err),
        .pre_lim  (lim[0]),
        .half_lim (lim[1]),
        .lr_lim   (lim[2])
    );

    assign clr      = cfg_wr || cfg_err;
    assign chain[0] = src_sel ? aud_tick : pclk_tick;

    // stage 0: prescaler, stage 1: bit clock, stage 2: frame clock
    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        aclk_tick_div #(.CNT_W(CNT_W)) div_i (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr),
            .tick_in (chain[s]),
            .limit   (lim[s]),
            .tick_out(chain[s+1])
        );
    end

    assign rclk_en  = chain[1];
    assign bclk_en  = chain[2];
    assign lrclk_en = chain[3];

    always_ff @(posedge clk) begin
        if (rst || cfg_wr) begin
            bclk_lvl <= 1'b0;
            lr_index <= 1'b0;
        end else begin
            if (bclk_en)  bclk_lvl <= !bclk_lvl;
            if (lrclk_en) lr_index <= !lr_index;
        end
    end

    // R6: no enable pulses while the ratio pair is flagged
    assert_err_silent_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !(rclk_en || bclk_en || lrclk_en));

    // R7: a write restarts the frame
    assert_write_restart_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (!lr_index && !bclk_lvl));

    // R5: the channel index only moves after a frame strobe or a write
    assert_lr_moves_on_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        (lr_index != $past(lr_index)) |-> ($past(lrclk_en) || $past(cfg_wr)));

    // R8: bit and frame strobes are single-cycle
    assert_bclk_single_R8: assert property (@(posedge clk) disable iff (rst)
        bclk_en |=> !bclk_en);
    assert_lrclk_single_R8: assert property (@(posedge clk) disable iff (rst)
        lrclk_en |=> !lrclk_en);

endmodule

// File: tb/aclk_gen_tb_top.sv
module aclk_gen_tb_top;
    localparam int PRE_W = 8;
    localparam int CFG_W = 8 + PRE_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pclk_tick = 1'b0;
    logic aud_tick = 1'b0;
    logic cfg_wr = 1'b0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic rclk_en, bclk_en, bclk_lvl, lrclk_en, lr_index, cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int aud_div = 3;
    int aud_cnt = 0;

    always #4 clk = !clk;

    aclk_gen #(.PRE_W(PRE_W)) dut_i (
        .clk(clk), .rst(rst), .pclk_tick(pclk_tick), .aud_tick(aud_tick),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .rclk_en(rclk_en),
        .bclk_en(bclk_en), .bclk_lvl(bclk_lvl), .lrclk_en(lrclk_en),
        .lr_index(lr_index), .cfg_err(cfg_err)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (aud_cnt + 1 >= aud_div) begin
            aud_cnt  <= 0;
            aud_tick <= 1'b1;
        end else begin
            aud_cnt  <= aud_cnt + 1;
            aud_tick <= 1'b0;
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int which);
        case (which)
            0: return rclk_en;
            1: return bclk_en;
            default: return lrclk_en;
        endcase
    endfunction

    task automatic measure(input int which, output int per);
        int guard;
        guard = 0;
        do begin @(negedge clk); guard++; end while (!pick(which) && guard < 20000);
        per = 0;
        do begin @(negedge clk); per++; end while (!pick(which) && per < 20000);
    endtask

    task automatic write_cfg(input logic [1:0] rc, input logic [1:0] bc,
                             input logic sel, input logic pen, input int pval);
        @(negedge clk);
        cfg_wdata = '0;
        cfg_wdata[1:0] = rc;
        cfg_wdata[3:2] = bc;
        cfg_wdata[4] = sel;
        cfg_wdata[7] = pen;
        cfg_wdata[8 +: PRE_W] = PRE_W'(pval);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic run_valid(input string tag, input logic [1:0] rc, input logic [1:0] bc,
                             input logic sel, input logic pen, input int pval,
                             input int exp_r, input int exp_b, input int exp_l);
        int p;
        logic lr0;
        write_cfg(rc, bc, sel, pen, pval);
        // R7: fresh frame right after the write
        check({tag, " R7 lr_index after write"}, int'(lr_index), 0);
        check({tag, " R7 bclk_lvl after write"}, int'(bclk_lvl), 0);
        check({tag, " R6 no error"}, int'(cfg_err), 0);
        measure(0, p); check({tag, " R2/R3 rclk spacing"}, p, exp_r);
        measure(1, p); check({tag, " R4 bclk spacing"}, p, exp_b);
        @(negedge clk); check({tag, " R8 bclk single cycle"}, int'(bclk_en), 0);
        measure(2, p); check({tag, " R5 lrclk spacing"}, p, exp_l);
        lr0 = lr_index;
        @(negedge clk);
        check({tag, " R5 lr_index toggles"}, int'(lr_index), int'(!lr0));
        check({tag, " R8 lrclk single cycle"}, int'(lrclk_en), 0);
    endtask

    task automatic run_error(input string tag, input logic [1:0] rc, input logic [1:0] bc);
        int pulses;
        write_cfg(rc, bc, 1'b0, 1'b0, 0);
        check({tag, " R6 error flag"}, int'(cfg_err), 1);
        pulses = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (rclk_en || bclk_en || lrclk_en) pulses++;
        end
        check({tag, " R6 no pulses"}, pulses, 0);
    endtask

    task automatic run_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 rclk_en in reset", int'(rclk_en), 0);
        check("R1 bclk_en in reset", int'(bclk_en), 0);
        check("R1 lrclk_en in reset", int'(lrclk_en), 0);
        check("R1 lr_index in reset", int'(lr_index), 0);
        check("R1 cfg_err in reset", int'(cfg_err), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 bclk_en after reset", int'(bclk_en), 0);
        check("R1 lr_index after reset", int'(lr_index), 0);
    endtask

    initial begin
        pclk_tick = 1'b1;
        run_reset();
        // 256/32, no prescaler: half=4, lr=32*4
        run_valid("basic", 2'd0, 2'd2, 1'b0, 1'b0, 0, 1, 4, 128);
        // audio source every 3 cycles, N=2, 384/24: half=8
        run_valid("audsrc", 2'd1, 2'd1, 1'b1, 1'b1, 2, 9, 72, 1728);
        // prescaler value set but disabled, 768/48: half=8
        run_valid("predis", 2'd3, 2'd3, 1'b0, 1'b0, 5, 1, 8, 384);
        // N=1, 512/16: half=16
        run_valid("pre1", 2'd2, 2'd0, 1'b0, 1'b1, 1, 2, 32, 512);
        run_error("bad256x24", 2'd0, 2'd1);
        run_error("bad512x48", 2'd2, 2'd3);
        // recovery after an error pair: 384/48 half=4
        run_valid("recover", 2'd1, 2'd3, 1'b0, 1'b0, 0, 1, 4, 192);
        finish_run();
    end

endmodule